// File: doc/BRIEF.md
# Serial converter conversion sequencer

This block is the host-side serial master that performs one conversion on a multichannel serial analog-to-digital converter. A request names an input channel, a single-ended or differential input selection, a unipolar or bipolar coding flag and a two-bit power-down mode. The block assembles the converter's command byte from these fields. It then runs one full-duplex transfer of 24 serial clocks in SPI mode 0, and returns a 14-bit conversion result together with a one-cycle completion pulse.

The transfer has three bytes. The first carries the command, and its leading bit is the start marker. During the second and third bytes the output line is held low, and the converter shifts its result back. The serial clock comes from the system clock through a parameterized divider. Chip select stays low from the first command bit until the last serial clock has fallen. A new request is taken only while the block is idle.

Top module: `adc_seq`

## Requirements
- R1: After a request is accepted, `cs_n` goes low and stays low for exactly 24 rising edges of `sclk`. It returns high at the same system clock edge as the 24th falling edge of `sclk`. `sclk` is low whenever `cs_n` is high.
- R2: The first 8 bits sent on `mosi`, MSB first, are: bit 7 = 1 (start marker), bits 6:4 = channel select code, bit 3 = `req_unipolar`, bit 2 = `req_single`, bits 1:0 = `req_pd`. The start marker is on `mosi` when `cs_n` falls.
- R3: The channel select code places `req_chan[0]` in bit 6, `req_chan[2]` in bit 5 and `req_chan[1]` in bit 4 of the command byte.
- R4: `mosi` is low for all 16 bits of the second and third bytes.
- R5: The bits sampled on `miso` during the second and third bytes form a 16-bit word, first bit as MSB. `result` equals bits [RES_OFFSET+13:RES_OFFSET] of that word, with RES_OFFSET = 1 by default.
- R6: `done` is high for exactly one system clock cycle at the end of each transfer. `result` changes only in that cycle and otherwise holds its value.
- R7: Mode 0 timing applies. `mosi` does not change at a rising `sclk` edge, and `miso` is sampled at rising edges. Each `sclk` period lasts 2*HALF_DIV system clocks (20 ns with the defaults).
- R8: While `rst` is high and after it is released, the outputs are `cs_n`=1, `sclk`=0, `mosi`=0, `done`=0, `req_ready`=1 and `result`=0.
- R9: `req_ready` is high only while idle. A `req_valid` seen while a transfer is in progress is ignored: it does not alter the running command byte and does not start another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a conversion |
| req_chan | input | 3 | Channel number |
| req_single | input | 1 | 1 = single-ended input, 0 = differential |
| req_unipolar | input | 1 | 1 = unipolar coding, 0 = bipolar |
| req_pd | input | 2 | Power-down mode field |
| req_ready | output | 1 | Idle, a request will be taken |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| done | output | 1 | One-cycle completion pulse |
| result | output | 14 | Conversion result |

## Verification
The bench runs a table of requests that spans all eight channel numbers, both input modes, both codings and every power-down value. This separates swapped select bits and misplaced flag bits in the captured command byte. The converter model replies with all-ones, all-zeros, alternating and asymmetric words. An off-by-one extraction window or a bit-order reversal therefore yields a result that differs from the expected one. Directed cases cover the reset state, a request held during a busy transfer, and a result that must be held across idle time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CMD_BITS    = 8;
    localparam int REPLY_BITS  = 16;
    localparam int FRAME_BITS  = CMD_BITS + REPLY_BITS;
    localparam int RESULT_BITS = 14;

    typedef struct packed {
        logic [2:0] chan;
        logic       single;
        logic       unipolar;
        logic [1:0] pd;
    } conv_req_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_t;

    // Channel bits go out interleaved: bit0 first, then bit2, then bit1.
    function automatic logic [2:0] chan_code(input logic [2:0] chan);
        return {chan[0], chan[2], chan[1]};
    endfunction

    function automatic logic [CMD_BITS-1:0] cmd_byte(input conv_req_t r);
        return {1'b1, chan_code(r.chan), r.unipolar, r.single, r.pd};
    endfunction

endpackage

// File: rtl/adc_seq_sclk_gen.sv
module adc_seq_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic tick;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            assign tick = run && (cnt_q == CW'(HALF_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || !run || tick) cnt_q <= '0;
                else                     cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate

    assign rise_evt = tick && !sclk;
    assign fall_evt = tick && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) sclk <= 1'b0;
        else if (tick)   sclk <= !sclk;
    end

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
    import adc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    input  logic                  rise_evt,
    input  logic                  fall_evt,
    input  logic                  miso,
    output logic                  mosi,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  frame_end
);
    localparam int BW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] tx_q;
    logic [BW-1:0]         bit_q;

    assign frame_end = fall_evt && (bit_q == BW'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            bit_q   <= BW'(FRAME_BITS - 1);
            mosi    <= 1'b0;
            rx_word <= '0;
        end else if (load) begin
            tx_q  <= load_word;
            bit_q <= '0;
            mosi  <= load_word[FRAME_BITS-1];
        end else begin
            if (rise_evt) rx_word <= {rx_word[FRAME_BITS-2:0], miso};
            if (fall_evt) begin
                tx_q <= tx_q << 1;
                if (frame_end) begin
                    mosi <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    mosi  <= tx_q[FRAME_BITS-2];
                end
            end
        end
    end

    // R4: no second start marker during the reply bytes
    p_mosi_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_q >= BW'(CMD_BITS)) |-> !mosi);

    // R1: the bit counter never runs past the frame
    p_bit_range_r1: assert property (@(posedge clk) disable iff (rst)
        bit_q <= BW'(FRAME_BITS - 1));

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int RES_OFFSET = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [2:0]             req_chan,
    input  logic                   req_single,
    input  logic                   req_unipolar,
    input  logic [1:0]             req_pd,
    output logic                   req_ready,
    output logic                   cs_n,
    output logic                   sclk,
    output logic                   mosi,
    input  logic                   miso,
    output logic                   done,
    output logic [RESULT_BITS-1:0] result
);
    localparam int LOW_WINDOW = (RES_OFFSET + RESULT_BITS <= REPLY_BITS) ? RES_OFFSET : 0;

    seq_state_t            state_q;
    conv_req_t             req;
    logic                  accept;
    logic                  rise_evt, fall_evt, frame_end;
    logic [FRAME_BITS-1:0] rx_word;
    logic [REPLY_BITS-1:0] reply;

    assign req       = '{chan: req_chan, single: req_single, unipolar: req_unipolar, pd: req_pd};
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign reply     = rx_word[REPLY_BITS-1:0];

    adc_seq_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .run      (state_q == ST_SHIFT),
        .sclk     (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    adc_seq_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word ({cmd_byte(req), {REPLY_BITS{1'b0}}}),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word),
        .frame_end (frame_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cs_n    <= 1'b1;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= frame_end;
            if (accept) begin
                state_q <= ST_SHIFT;
                cs_n    <= 1'b0;
            end else if (frame_end) begin
                state_q <= ST_IDLE;
                cs_n    <= 1'b1;
                result  <= reply[LOW_WINDOW +: RESULT_BITS];
            end
        end
    end

    // R1: clock stays low outside chip select
    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R2: start marker present when chip select falls
    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> mosi);

    // R6: single-cycle completion pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: result only moves with done
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R7: data line steady at a rising serial clock edge
    p_mosi_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi));

    // R9: a transfer starts only from an idle request
    p_accept_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> ($past(req_ready) && $past(req_valid)));

endmodule

// File: tb/adc_seq_tb_top.sv
`timescale 1ns/1ps
module adc_seq_tb_top;

    localparam int  HALF_DIV = 2;
    localparam int  OFF      = 1;
    localparam real TCLK     = 5.0;

    // {chan[2:0], single, unipolar, pd[1:0], converter reply word[23:0]}
    localparam logic [30:0] VECS [8] = '{
        {3'd0, 1'b1, 1'b1, 2'b11, 24'h00_FFFF},
        {3'd1, 1'b0, 1'b0, 2'b00, 24'hFF_0000},
        {3'd2, 1'b1, 1'b0, 2'b01, 24'h00_AAAA},
        {3'd3, 1'b0, 1'b1, 2'b10, 24'h00_5555},
        {3'd4, 1'b1, 1'b1, 2'b00, 24'h00_8001},
        {3'd5, 1'b0, 1'b0, 2'b11, 24'h00_1234},
        {3'd6, 1'b1, 1'b0, 2'b10, 24'h00_7FFE},
        {3'd7, 1'b0, 1'b1, 2'b01, 24'h00_C3A5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_chan = '0;
    logic        req_single = 1'b0;
    logic        req_unipolar = 1'b0;
    logic [1:0]  req_pd = '0;
    logic        req_ready, cs_n, sclk, mosi, done;
    logic        miso = 1'b0;
    logic [13:0] result;

    int          checks = 0;
    int          errors = 0;
    int          rise_cnt = 0;
    logic [23:0] cap;
    realtime     t_r1, t_r2;

    always #(TCLK/2) clk = ~clk;

    adc_seq #(.HALF_DIV(HALF_DIV), .RES_OFFSET(OFF)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .req_single(req_single), .req_unipolar(req_unipolar), .req_pd(req_pd),
        .req_ready(req_ready), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .done(done), .result(result)
    );

    always @(posedge sclk) if (!cs_n) rise_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input logic [2:0] ch, input logic sgl,
                                           input logic uni, input logic [1:0] pd);
        return {1'b1, ch[0], ch[2], ch[1], uni, sgl, pd};
    endfunction

    task automatic send_req(input logic [2:0] ch, input logic sgl,
                            input logic uni, input logic [1:0] pd);
        @(negedge clk);
        req_chan = ch; req_single = sgl; req_unipolar = uni; req_pd = pd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic converter(input logic [23:0] word);
        @(negedge cs_n);
        miso = word[23];
        for (int i = 0; i < 24; i++) begin
            @(posedge sclk);
            cap[23-i] = mosi;
            if (i == 0) t_r1 = $realtime;
            if (i == 1) t_r2 = $realtime;
            if (i < 23) begin
                @(negedge sclk);
                miso = word[22-i];
            end
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_vec(input logic [30:0] v);
        logic [2:0]  ch  = v[30:28];
        logic        sgl = v[27];
        logic        uni = v[26];
        logic [1:0]  pd  = v[25:24];
        logic [23:0] w   = v[23:0];
        logic [7:0]  ec  = exp_cmd(ch, sgl, uni, pd);
        logic [15:0] rep = w[15:0];
        rise_cnt = 0;
        fork
            send_req(ch, sgl, uni, pd);
            converter(w);
        join
        chk("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
        wait_done();
        chk("R6 done seen", {31'd0, done}, 32'd1);
        chk("R2 command byte", {24'd0, cap[23:16]}, {24'd0, ec});
        chk("R3 channel code", {29'd0, cap[22:20]}, {29'd0, ec[6:4]});
        chk("R4 reply bytes quiet", {16'd0, cap[15:0]}, 32'd0);
        chk("R5 result", {18'd0, result}, {18'd0, rep[OFF +: 14]});
        chk("R1 rise count", rise_cnt, 32'd24);
        chk("R1 cs released", {31'd0, cs_n}, 32'd1);
        chk("R7 sclk period ps", int'((t_r2 - t_r1) * 1000.0), int'(2.0 * HALF_DIV * TCLK * 1000.0));
        @(negedge clk);
        chk("R6 done one cycle", {31'd0, done}, 32'd0);
        chk("R9 ready when idle", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        #(TCLK * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog (all): actual hung expected finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [13:0] held;
        repeat (4) @(negedge clk);
        // R8: state during reset
        chk("R8 cs_n in reset", {31'd0, cs_n}, 32'd1);
        chk("R8 sclk in reset", {31'd0, sclk}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 mosi", {31'd0, mosi}, 32'd0);
        chk("R8 done", {31'd0, done}, 32'd0);
        chk("R8 ready", {31'd0, req_ready}, 32'd1);
        chk("R8 result", {18'd0, result}, 32'd0);

        foreach (VECS[k]) run_vec(VECS[k]);

        // R9: a request held during a busy transfer is ignored
        rise_cnt = 0;
        fork
            send_req(3'd2, 1'b1, 1'b1, 2'b00);
            converter(24'h00_0F0F);
            begin
                repeat (12) @(negedge clk);
                req_chan = 3'd7; req_single = 1'b0; req_unipolar = 1'b0; req_pd = 2'b11;
                req_valid = 1'b1;
                repeat (20) @(negedge clk);
                req_valid = 1'b0;
            end
        join
        wait_done();
        chk("R9 command unaffected", {24'd0, cap[23:16]}, {24'd0, exp_cmd(3'd2, 1'b1, 1'b1, 2'b00)});
        chk("R9 single transfer", rise_cnt, 32'd24);
        held = result;
        chk("R5 result busy case", {18'd0, held}, {18'd0, 14'(16'h0F0F >> OFF)});
        repeat (40) begin
            @(negedge clk);
            if (cs_n !== 1'b1) break;
        end
        chk("R9 no second transfer", {31'd0, cs_n}, 32'd1);
        chk("R6 result held idle", {18'd0, result}, {18'd0, held});

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule